// File: doc/BRIEF.md
# Memory ECC Error Logger with System-Error Signalling

This block sits beside a memory ECC checker and records the errors it reports. The checker delivers single-cycle event pulses for two error classes, correctable single-bit and uncorrectable multi-bit, each with the number of the DRAM row that produced it. For each class the block keeps a sticky flag and the row of the first error seen since the flag was last cleared. Software reads both through an 8-bit status register and clears each flag by writing a one to it.

An 8-bit command register chooses which error classes may raise the active-low system-error output. It also sets how long that output stays low: either one PCI clock interval, or until software clears the flags. The output only changes on cycles where the PCI clock-enable tick is high, so it lines up with the slower bus clock. A third command bit asks the datapath to force bad parity when an uncorrectable error arrives. The block signals that request with a one-cycle pulse.

Top module: `ecc_err_reporter`

## Requirements
- R1: After reset the status and command registers read 0, `serr_n` is 1 and `bad_par_req` is 0.
- R2: `cfg_sel`=0 addresses the command register and `cfg_sel`=1 the status register; `cfg_rdata` shows the selected register combinationally. In the command register only bits 0, 1, 2 and 7 are writable, and the other bits read 0.
- R3: A correctable-error pulse sets status bit 0. If that flag was 0, the pulse also captures `sbe_row` into status bits 3:1. Both are visible the cycle after the pulse.
- R4: An uncorrectable-error pulse sets status bit 4. If that flag was 0, the pulse also captures `mbe_row` into status bits 7:5.
- R5: While a flag is set, later errors of the same class leave its row field unchanged.
- R6: Writing 1 to status bit 0 or bit 4 clears that flag and zeroes its row field. Writing 0 to a flag, or writing to the row bits, has no effect.
- R7: When an error pulse of a class arrives in the same cycle as a clear of that class's flag, the flag stays set and keeps its row.
- R8: Command bit 0 lets correctable errors raise the system error, and command bit 1 lets uncorrectable errors raise it. A class whose enable bit is 0 never drives `serr_n` low.
- R9: With command bit 7 at 0, an enabled error drives `serr_n` low at the first clock-enable tick at or after the event. `serr_n` returns to 1 at the next tick.
- R10: With command bit 7 at 1, `serr_n` goes low at the first tick after an enabled error. It stays low while any enabled flag is set, and returns to 1 at the first tick after the flags are cleared.
- R11: `serr_n` changes only in cycles where `pci_ce` is 1.
- R12: An uncorrectable-error pulse with command bit 2 set produces a `bad_par_req` pulse exactly one cycle long, in the following cycle. Without command bit 2, no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pci_ce | input | 1 | PCI clock-enable tick |
| sbe_evt | input | 1 | Correctable single-bit error pulse |
| sbe_row | input | ROW_W | DRAM row of the correctable error |
| mbe_evt | input | 1 | Uncorrectable multi-bit error pulse |
| mbe_row | input | ROW_W | DRAM row of the uncorrectable error |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 command, 1 status |
| cfg_wdata | input | 2*(ROW_W+1) | Write data |
| cfg_rdata | output | 2*(ROW_W+1) | Read data of the selected register |
| serr_n | output | 1 | Active-low system-error output |
| bad_par_req | output | 1 | Force-bad-parity request pulse |

## Verification
The bench builds the block with the default `ROW_W` of 3, which gives 8-bit registers and eight DRAM rows. It sweeps all 16 combinations of the four writable command bits, against every mix of error classes (one class, the other, or both at once) and all eight row numbers. This exercises every enable and duration setting with each row value in both captured fields. Directed sequences cover the register mask, writes of zero and writes to the row bits, and an error arriving in the same cycle as its clear.

// File: rtl/ecc_err_pkg.sv
// Shared definitions for the ECC error logger.
// Assumes: command bit positions are fixed; the duration bit is the register MSB.
package ecc_err_pkg;
    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_STAT = 1'b1
    } cfg_sel_e;

    localparam int CMD_SBE_EN  = 0;
    localparam int CMD_MBE_EN  = 1;
    localparam int CMD_BADPAR  = 2;
endpackage

// File: rtl/ecc_cmd_reg.sv
// Command register: keeps only the defined control bits, the rest read zero.
// Assumes: wr_en is already qualified with the command select.
module ecc_cmd_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cmd
);
    import ecc_err_pkg::*;

    localparam logic [DATA_W-1:0] CMD_MASK =
        (DATA_W'(1) << CMD_SBE_EN) | (DATA_W'(1) << CMD_MBE_EN) |
        (DATA_W'(1) << CMD_BADPAR) | (DATA_W'(1) << (DATA_W-1));

    // Store masked write data.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= '0;
        else if (wr_en)  cmd <= wdata & CMD_MASK;
    end

    // Undefined bits never become set.
    always @(posedge clk) begin
        if (rst_n) assert_cmd_mask_R2: assert ((cmd & ~CMD_MASK) == '0);
    end
endmodule

// File: rtl/ecc_err_class_log.sv
// One error class: sticky flag plus the row of the first error since clear.
// Assumes: evt is a single-cycle pulse; clr is a write-one-to-clear strobe.
module ecc_err_class_log #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [ROW_W-1:0] row_in,
    input  logic             clr,
    output logic             flag,
    output logic [ROW_W-1:0] row
);
    // Flag: an event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (evt)    flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end

    // Row: captured only on a 0->1 flag change, zeroed on a plain clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                row <= '0;
        else if (evt && !flag)     row <= row_in;
        else if (clr && !evt)      row <= '0;
    end

    assert_row_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !flag) |=> (flag && row == $past(row_in)));
    assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> $stable(row));
    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> (!flag && row == '0));
endmodule

// File: rtl/ecc_serr_gen.sv
// System-error output: pulse or held mode, updated only on clock-enable ticks.
// Assumes: trig is the enabled error pulse; held_cond is "an enabled flag is set".
module ecc_serr_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic trig,
    input  logic hold_mode,
    input  logic held_cond,
    output logic serr_n
);
    logic pending;

    // Remember an enabled error until the next tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)     pending <= 1'b0;
        else if (ce)    pending <= 1'b0;
        else if (trig)  pending <= 1'b1;
    end

    // Drive the output only at ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)   serr_n <= 1'b1;
        else if (ce)  serr_n <= !(pending || trig || (hold_mode && held_cond));
    end

    assert_ce_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(serr_n));
    assert_pulse_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !hold_mode && !pending && !trig) |=> serr_n);
    assert_hold_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && hold_mode && held_cond) |=> !serr_n);
endmodule

// File: rtl/ecc_err_reporter.sv
// Top: two error-class loggers, command register, system-error and parity request.
// Assumes: status layout {mbe_row, mbe_flag, sbe_row, sbe_flag}; reads are combinational.
module ecc_err_reporter #(
    parameter int ROW_W  = 3,
    parameter int DATA_W = 2 * (ROW_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pci_ce,
    input  logic              sbe_evt,
    input  logic [ROW_W-1:0]  sbe_row,
    input  logic              mbe_evt,
    input  logic [ROW_W-1:0]  mbe_row,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              serr_n,
    output logic              bad_par_req
);
    import ecc_err_pkg::*;

    localparam int MBE_FLAG_BIT = ROW_W + 1;
    localparam int HOLD_BIT     = DATA_W - 1;

    logic [DATA_W-1:0] cmd;
    logic              sbe_flag, mbe_flag;
    logic [ROW_W-1:0]  sbe_row_q, mbe_row_q;
    logic              stat_wr, cmd_wr;
    logic              trig, held_cond;

    assign stat_wr = cfg_wr && (cfg_sel == SEL_STAT);
    assign cmd_wr  = cfg_wr && (cfg_sel == SEL_CMD);

    ecc_cmd_reg #(.DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_en(cmd_wr), .wdata(cfg_wdata), .cmd(cmd)
    );

    ecc_err_class_log #(.ROW_W(ROW_W)) u_sbe (
        .clk(clk), .rst_n(rst_n), .evt(sbe_evt), .row_in(sbe_row),
        .clr(stat_wr && cfg_wdata[0]), .flag(sbe_flag), .row(sbe_row_q)
    );

    ecc_err_class_log #(.ROW_W(ROW_W)) u_mbe (
        .clk(clk), .rst_n(rst_n), .evt(mbe_evt), .row_in(mbe_row),
        .clr(stat_wr && cfg_wdata[MBE_FLAG_BIT]), .flag(mbe_flag), .row(mbe_row_q)
    );

    assign trig      = (sbe_evt && cmd[CMD_SBE_EN]) || (mbe_evt && cmd[CMD_MBE_EN]);
    assign held_cond = (sbe_flag && cmd[CMD_SBE_EN]) || (mbe_flag && cmd[CMD_MBE_EN]);

    ecc_serr_gen u_serr (
        .clk(clk), .rst_n(rst_n), .ce(pci_ce), .trig(trig),
        .hold_mode(cmd[HOLD_BIT]), .held_cond(held_cond), .serr_n(serr_n)
    );

    // One-cycle bad-parity request after an uncorrectable error.
    always_ff @(posedge clk) begin
        if (!rst_n) bad_par_req <= 1'b0;
        else        bad_par_req <= mbe_evt && cmd[CMD_BADPAR];
    end

    // Register read mux.
    always_comb begin
        if (cfg_sel == SEL_STAT) cfg_rdata = {mbe_row_q, mbe_flag, sbe_row_q, sbe_flag};
        else                     cfg_rdata = cmd;
    end

    assert_badpar_on_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mbe_evt && cmd[CMD_BADPAR]) |=> bad_par_req);
    assert_badpar_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !mbe_evt |=> !bad_par_req);
endmodule

// File: tb/test_ecc_err_reporter.sv
module test_ecc_err_reporter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pci_ce = 1'b0;
    logic       sbe_evt = 1'b0, mbe_evt = 1'b0;
    logic [2:0] sbe_row = '0, mbe_row = '0;
    logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       serr_n, bad_par_req;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ecc_err_reporter i_ecc_err_reporter (
        .clk(clk), .rst_n(rst_n), .pci_ce(pci_ce),
        .sbe_evt(sbe_evt), .sbe_row(sbe_row), .mbe_evt(mbe_evt), .mbe_row(mbe_row),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .serr_n(serr_n), .bad_par_req(bad_par_req)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        cyc();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        cfg_sel = sel;
        #1;
        d = cfg_rdata;
    endtask

    task automatic tick();
        pci_ce = 1'b1;
        cyc();
        pci_ce = 1'b0;
    endtask

    task automatic run_all();
        logic [7:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1 reset state
        rd(1'b0, v); chk("R1 cmd", v, 8'h00);
        rd(1'b1, v); chk("R1 status", v, 8'h00);
        chk("R1 serr_n", {7'd0, serr_n}, 8'h01);
        chk("R1 bad_par", {7'd0, bad_par_req}, 8'h00);
        // R2 mask and select
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R2 cmd mask", v, 8'h87);
        rd(1'b1, v); chk("R2 status select", v, 8'h00);
        wr(1'b0, 8'h00);
        // R6 zero-writes and row-bit writes ignored
        sbe_evt = 1'b1; sbe_row = 3'd6; mbe_evt = 1'b1; mbe_row = 3'd3;
        cyc();
        sbe_evt = 1'b0; mbe_evt = 1'b0;
        wr(1'b1, 8'h00);
        rd(1'b1, v); chk("R6 write zero", v, 8'h7D);
        wr(1'b1, 8'hEE);
        rd(1'b1, v); chk("R6 row bits", v, 8'h7D);
        wr(1'b1, 8'h01);
        rd(1'b1, v); chk("R6 clear sbe only", v, 8'h70);
        wr(1'b1, 8'h10);
        rd(1'b1, v); chk("R6 clear mbe", v, 8'h00);
        // R7 event in same cycle as clear
        sbe_evt = 1'b1; sbe_row = 3'd2;
        cyc();
        sbe_row = 3'd5;
        wr(1'b1, 8'h01);
        sbe_evt = 1'b0;
        rd(1'b1, v); chk("R7 sbe race", v, 8'h05);
        mbe_evt = 1'b1; mbe_row = 3'd4;
        cyc();
        mbe_row = 3'd1;
        wr(1'b1, 8'h10);
        mbe_evt = 1'b0;
        rd(1'b1, v); chk("R7 mbe race", v, 8'h95);
        wr(1'b1, 8'h11);
        // Sweep: command bits x class mix x row
        for (int cm = 0; cm < 16; cm++) begin
            for (int cl = 1; cl < 4; cl++) begin
                for (int r = 0; r < 8; r++) begin
                    logic [7:0] cmdv, exp_st;
                    logic       s_on, m_on, on, hold, bp;
                    cmdv = {cm[3], 4'b0000, cm[2:0]};
                    s_on = cl[0] & cm[0];
                    m_on = cl[1] & cm[1];
                    on   = s_on | m_on;
                    hold = cm[3];
                    bp   = cl[1] & cm[2];
                    exp_st = (cl[0] ? {4'd0, 3'(r), 1'b1} : 8'd0) |
                             (cl[1] ? {3'(7 - r), 1'b1, 4'd0} : 8'd0);
                    wr(1'b0, cmdv);
                    wr(1'b1, 8'h11);
                    tick();
                    chk("R10 idle", {7'd0, serr_n}, 8'h01);
                    sbe_evt = cl[0]; sbe_row = 3'(r);
                    mbe_evt = cl[1]; mbe_row = 3'(7 - r);
                    cyc();
                    sbe_evt = 1'b0; mbe_evt = 1'b0;
                    rd(1'b1, v); chk("R3 R4 capture", v, exp_st);
                    chk("R12 pulse", {7'd0, bad_par_req}, {7'd0, bp});
                    chk("R11 no tick", {7'd0, serr_n}, 8'h01);
                    sbe_evt = cl[0]; sbe_row = 3'(r ^ 3);
                    mbe_evt = cl[1]; mbe_row = 3'(r ^ 5);
                    cyc();
                    sbe_evt = 1'b0; mbe_evt = 1'b0;
                    cyc();
                    rd(1'b1, v); chk("R5 keep row", v, exp_st);
                    chk("R12 one cycle", {7'd0, bad_par_req}, 8'h00);
                    tick();
                    chk("R8 enable", {7'd0, serr_n}, {7'd0, ~on});
                    cyc();
                    chk("R11 hold between ticks", {7'd0, serr_n}, {7'd0, ~on});
                    tick();
                    chk(hold ? "R10 held" : "R9 released", {7'd0, serr_n},
                        {7'd0, ~(on & hold)});
                    wr(1'b1, 8'h11);
                    rd(1'b1, v); chk("R6 clear all", v, 8'h00);
                    tick();
                    chk("R10 release", {7'd0, serr_n}, 8'h01);
                end
            end
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule